// File: doc/BRIEF.md
# Prime-Field Add/Subtract/Triple/Halve Unit

This block performs the small modular operations that elliptic-curve point addition and point doubling need around the field multiplier. It works over the 256-bit prime p = 2^256 − 2^224 − 2^96 + 2^64 − 1. Two operands that already lie in [0, p) are presented with a 2-bit function code. One clock later the unit returns a single result, also reduced into [0, p). A point-arithmetic datapath normally instantiates two of these units beside one modular multiplier.

The functions are sum, difference, tripling and halving, all modulo p. The unit computes all four functions combinationally from a shared set of correcting adders and a halving stage. A function-code multiplexer selects one, and the selected value is captured in an output register. A new operation may be issued on every cycle.

Top module: `fp_modalu`

## Requirements
- R1: While rst_n is low at a rising clock edge, the unit clears out_valid to 0 and result to 0 at that edge.
- R2: out_valid is high in the cycle that follows each cycle in which in_valid was sampled high, and low in the cycle that follows each cycle in which in_valid was sampled low.
- R3: Function code 2'b00 returns (a + b) mod p.
- R4: Function code 2'b01 returns (a − b) mod p. A negative raw difference is corrected by adding p.
- R5: Function code 2'b10 returns (3·a) mod p. The b input has no effect on the result.
- R6: Function code 2'b11 returns the value r in [0, p) with 2·r ≡ a (mod p). This is a/2 when a is even and (a + p)/2 when a is odd. The b input has no effect on the result.
- R7: For operands in [0, p), every result presented with out_valid high is below p. This includes the edge operands 0, 1 and p − 1.
- R8: result keeps its value through every cycle that follows a cycle in which in_valid was sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and function code are valid this cycle |
| op | input | 2 | Function code: 00 sum, 01 difference, 10 triple, 11 halve |
| a | input | 256 | First operand, in [0, p) |
| b | input | 256 | Second operand, in [0, p); used only by sum and difference |
| out_valid | output | 1 | result holds a new value this cycle |
| result | output | 256 | Reduced result, registered |

## Verification
The arithmetic properties assume that both operands are already below p. Each such property checks a result by undoing the operation: it adds b back after a difference, takes b away after a sum, and doubles the result after a halving. These checks are guarded on a < p and b < p, so an unreduced operand drives no conclusion. The stimulus keeps within that range by folding every random 256-bit draw once by p, since 2^256 is below 2p. It also draws edge values only from the reduced set: 0, 1, 2, (p−1)/2, (p+1)/2, p−2 and p−1.

// File: rtl/fp_modalu_pkg.sv
// Package for the prime-field add/subtract/triple/halve unit.
// Holds the default field width, the default modulus and the function-code type.
package fp_modalu_pkg;

    localparam int unsigned FIELD_W = 256;

    // Default modulus: 2^256 - 2^224 - 2^96 + 2^64 - 1
    localparam logic [FIELD_W-1:0] FIELD_P =
        256'hFFFFFFFE_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_00000000_FFFFFFFF_FFFFFFFF;

    // Function codes; the encoding is visible at the op port
    typedef enum logic [1:0] {
        FN_SUM    = 2'b00,
        FN_DIFF   = 2'b01,
        FN_TRIPLE = 2'b10,
        FN_HALVE  = 2'b11
    } modfn_e;

endpackage

// File: rtl/fp_mod_addsub.sv
// Correcting adder/subtractor modulo MOD.
// Assumes x and y lie in [0, MOD).
// Sum mode: subtracts MOD once when x + y >= MOD.
// Difference mode: adds MOD once when x - y < 0.
// The output is always in [0, MOD). Purely combinational.
module fp_mod_addsub #(
    parameter int unsigned     W   = 256,
    parameter logic [W-1:0]    MOD = fp_modalu_pkg::FIELD_P
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         do_sub,
    output logic [W-1:0] z
);

    localparam int unsigned EW = W + 1;   // one carry/borrow bit
    localparam int unsigned TW = W + 2;   // room for the trial subtraction sign

    logic [EW-1:0] sum_raw;
    logic [TW-1:0] sum_trial;
    logic [EW-1:0] diff_raw;
    logic [EW-1:0] diff_fix;
    logic          sum_ge_mod;
    logic          diff_neg;
    logic          unused_bits;

    // Raw sum and its trial subtraction of the modulus
    always_comb begin
        sum_raw    = {1'b0, x} + {1'b0, y};
        sum_trial  = {1'b0, sum_raw} - {2'b00, MOD};
        sum_ge_mod = ~sum_trial[TW-1];
    end

    // Raw difference and its add-back of the modulus
    always_comb begin
        diff_raw = {1'b0, x} - {1'b0, y};
        diff_neg = diff_raw[W];
        diff_fix = diff_raw + {1'b0, MOD};
    end

    // Pick the corrected value for the requested mode
    always_comb begin
        if (do_sub) begin
            z = diff_neg ? diff_fix[W-1:0] : diff_raw[W-1:0];
        end else begin
            z = sum_ge_mod ? sum_trial[W-1:0] : sum_raw[W-1:0];
        end
    end

    assign unused_bits = ^{sum_trial[W], diff_fix[W]};

endmodule

// File: rtl/fp_mod_halve.sv
// Halving modulo an odd MOD.
// Assumes x lies in [0, MOD) and MOD is odd.
// An even x is shifted right. An odd x first has MOD added in a W+1 bit sum
// so that the sum is even, then it is shifted right.
// The output is in [0, MOD). Purely combinational.
module fp_mod_halve #(
    parameter int unsigned     W   = 256,
    parameter logic [W-1:0]    MOD = fp_modalu_pkg::FIELD_P
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] z
);

    logic [W:0] evened;
    logic       unused_bits;

    // Make the dividend even, then drop the low bit
    always_comb begin
        evened = {1'b0, x} + (x[0] ? {1'b0, MOD} : {(W+1){1'b0}});
        z      = evened[W:1];
    end

    assign unused_bits = evened[0];

endmodule

// File: rtl/fp_modalu.sv
// Prime-field add/subtract/triple/halve unit, top level.
// Assumes a and b lie in [0, MOD).
// All four functions are computed combinationally from the same operands.
// op selects one of them, and the selection is registered when in_valid is high.
// result holds its value when in_valid is low.
// Latency is one cycle, and a new operation may be issued every cycle.
module fp_modalu #(
    parameter int unsigned     W   = fp_modalu_pkg::FIELD_W,
    parameter logic [W-1:0]    MOD = fp_modalu_pkg::FIELD_P
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         out_valid,
    output logic [W-1:0] result
);

    import fp_modalu_pkg::*;

    modfn_e       fn;
    logic [W-1:0] sd_res;     // sum or difference
    logic [W-1:0] dbl_res;    // 2a mod MOD
    logic [W-1:0] tri_res;    // 3a mod MOD
    logic [W-1:0] half_res;   // a/2 mod MOD
    logic [W-1:0] sel_res;

    assign fn = modfn_e'(op);

    // Sum or difference of the two operands
    fp_mod_addsub #(.W(W), .MOD(MOD)) u_sumdiff (
        .x      (a),
        .y      (b),
        .do_sub (fn == FN_DIFF),
        .z      (sd_res)
    );

    // First tripling stage: a + a, reduced
    fp_mod_addsub #(.W(W), .MOD(MOD)) u_double (
        .x      (a),
        .y      (a),
        .do_sub (1'b0),
        .z      (dbl_res)
    );

    // Second tripling stage: 2a + a, reduced
    fp_mod_addsub #(.W(W), .MOD(MOD)) u_triple (
        .x      (dbl_res),
        .y      (a),
        .do_sub (1'b0),
        .z      (tri_res)
    );

    // Halving of the first operand
    fp_mod_halve #(.W(W), .MOD(MOD)) u_halve (
        .x (a),
        .z (half_res)
    );

    // Select the function requested by the code
    always_comb begin
        unique case (fn)
            FN_SUM,
            FN_DIFF:   sel_res = sd_res;
            FN_TRIPLE: sel_res = tri_res;
            FN_HALVE:  sel_res = half_res;
            default:   sel_res = sd_res;
        endcase
    end

    // Output register with valid flag; result holds while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sel_res;
            end
        end
    end

endmodule

// File: rtl/fp_modalu_chk.sv
// Assertion checker for fp_modalu, attached with bind.
// Arithmetic properties are checked by inverting the operation.
// They only apply when the issued operands are below MOD.
module fp_modalu_chk #(
    parameter int unsigned     W   = 256,
    parameter logic [W-1:0]    MOD = fp_modalu_pkg::FIELD_P
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [1:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         out_valid,
    input  logic [W-1:0] result
);

    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         in_range;
    logic [W:0]   back_add;
    logic [W:0]   back_add_red;
    logic [W:0]   back_sub;
    logic [W:0]   twice;
    logic [W:0]   twice_red;

    // Capture the issued operands for checks one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= a;
            b_q <= b;
        end
    end

    // Build the inverse relations from the registered result
    always_comb begin
        in_range     = (a < MOD) && (b < MOD);
        back_add     = {1'b0, result} + {1'b0, b_q};
        back_add_red = (back_add >= {1'b0, MOD}) ? back_add - {1'b0, MOD} : back_add;
        back_sub     = (result >= b_q) ? {1'b0, result} - {1'b0, b_q}
                                       : {1'b0, result} + {1'b0, MOD} - {1'b0, b_q};
        twice        = {result, 1'b0};
        twice_red    = (twice >= {1'b0, MOD}) ? twice - {1'b0, MOD} : twice;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_sum_inverse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && in_range) |=> back_sub == {1'b0, a_q});

    p_diff_inverse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b01 && in_range) |=> back_add_red == {1'b0, a_q});

    p_halve_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11 && in_range) |=> twice_red == {1'b0, a_q});

    p_below_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_range) |=> result < MOD);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

endmodule

bind fp_modalu fp_modalu_chk #(.W(W), .MOD(MOD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fp_modalu_tb.sv
// Scoreboard bench for fp_modalu: the driver queues expected results and
// the monitor compares them as outputs appear.
module fp_modalu_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;
    localparam logic [255:0] P = fp_modalu_pkg::FIELD_P;
    localparam logic [259:0] PX = {4'b0, P};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op = 2'b00;
    logic [255:0] a = '0;
    logic [255:0] b = '0;
    logic         out_valid;
    logic [255:0] result;

    int checks = 0;
    int fails  = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;
    logic [255:0] last_res = '0;
    logic [257:0] exp_q[$];   // {op, expected}

    fp_modalu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .out_valid(out_valid), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [255:0] ref_model(input logic [1:0] o,
                                               input logic [255:0] x,
                                               input logic [255:0] y);
        logic [259:0] t;
        case (o)
            2'b00:   t = ({4'b0, x} + {4'b0, y}) % PX;
            2'b01:   t = ({4'b0, x} + PX - {4'b0, y}) % PX;
            2'b10:   t = ({4'b0, x} * 260'd3) % PX;
            default: t = x[0] ? (({4'b0, x} + PX) >> 1) : ({4'b0, x} >> 1);
        endcase
        return t[255:0];
    endfunction

    function automatic logic [255:0] rand_elem();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        if (v >= P) v = v - P;
        return v;
    endfunction

    function automatic string tag_of(input logic [1:0] o);
        case (o)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic report(input bit ok, input string req,
                          input logic [255:0] act, input logic [255:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic [255:0] x, input logic [255:0] y);
        @(negedge clk);
        op = o; a = x; b = y; in_valid = 1'b1;
        exp_q.push_back({o, ref_model(o, x, y)});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a = rand_elem(); b = rand_elem(); op = 2'($urandom);
        end
    endtask

    // Monitor: compare each output with the head of the scoreboard
    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    report(1'b0, "R2 unexpected out_valid", {255'b0, out_valid}, '0);
                end else begin
                    logic [257:0] item;
                    item = exp_q.pop_front();
                    report(result == item[255:0], tag_of(item[257:256]), result, item[255:0]);
                    report(result < P, "R7 result below p", result, P);
                end
                last_res = result;
            end else begin
                report(result == last_res, "R8 hold while idle", result, last_res);
            end
        end
    end

    // Watchdog: an overrun counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [255:0] edges[7];
        edges[0] = '0;
        edges[1] = 256'd1;
        edges[2] = 256'd2;
        edges[3] = (P - 256'd1) >> 1;
        edges[4] = (P + 256'd1) >> 1;
        edges[5] = P - 256'd2;
        edges[6] = P - 256'd1;

        // R1: reset state
        repeat (3) @(negedge clk);
        report(out_valid == 1'b0, "R1 out_valid in reset", {255'b0, out_valid}, '0);
        report(result == '0, "R1 result in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        report(out_valid == 1'b0, "R1 out_valid after reset", {255'b0, out_valid}, '0);
        monitor_on = 1'b1;

        // Edge operands, every function, back to back (R3..R7)
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    issue(2'(o), edges[i], edges[j]);
        idle(2);

        // R5, R6: b has no effect; same a with differing b
        for (int i = 0; i < 7; i++) begin
            issue(2'b10, edges[i], rand_elem());
            issue(2'b10, edges[i], edges[6 - i]);
            issue(2'b11, edges[i], rand_elem());
            issue(2'b11, edges[i], edges[6 - i]);
        end
        idle(1);

        // Random operands with random gaps (R2, R8)
        for (int n = 0; n < 400; n++) begin
            issue(2'($urandom), rand_elem(), rand_elem());
            if (($urandom % 4) == 0) idle(1 + ($urandom % 3));
        end
        idle(3);

        // R2: every issued operation produced exactly one output
        monitor_on = 1'b0;
        report(exp_q.size() == 0, "R2 outstanding results", 256'(exp_q.size()), '0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule